// File: doc/BRIEF.md
# Strided Interleave DMA Address Generator

This block produces the address stream for an interleaved copy between a contiguous scratchpad region and main memory. A single start pulse sets up a job: it gives the total number of 16-byte quadwords, a run length, a gap length and the two base addresses. For every quadword moved, the block offers one pair of byte addresses, one for the scratchpad and one for memory. The scratchpad address always steps by 16. The memory address steps by 16 inside a run. At the end of each run it jumps forward past a gap of skipped quadwords. The last run may be shorter than the run length. A run length of zero turns the job into a single contiguous run that covers the whole count.

The address pairs leave on a valid/ready stream. The block offers a pair whenever a job is active, and it moves on only in a cycle where both valid and ready are high. While ready is low, valid stays high and both addresses hold their values. The downstream side may hold ready low for as long as it needs, and at most one pair is accepted per cycle. Start, the job fields, busy, done and the remaining count are plain level or pulse signals with no handshake. When the final pair is accepted, done pulses for one cycle and the remaining count reads zero.

Top module: `strided_dma_addr_gen`

## Requirements
- R1: After reset, pair_valid_o, done_o and busy_o are 0 and remain_o is 0.
- R2: A start_i seen while idle with a nonzero total raises pair_valid_o and busy_o on the next cycle. The first pair offered is (spad_base_i, mem_base_i).
- R3: Each accepted pair (pair_valid_o and pair_ready_i both high) advances spad_addr_o by 16. The scratchpad side never skips.
- R4: Inside a run, each accepted pair advances mem_addr_o by 16. The pair that ends a run of run_qw_i quadwords advances mem_addr_o by (skip_qw_i + 1) * 16.
- R5: A run_qw_i of 0 makes the whole total one run, so mem_addr_o advances by 16 on every accepted pair.
- R6: When the total is not a multiple of the run length, the final run moves only the quadwords that remain, and the job ends after exactly total_qw_i accepted pairs.
- R7: While pair_valid_o is high and pair_ready_i is low, pair_valid_o stays high on the next cycle and both addresses hold their values.
- R8: done_o is a one-cycle pulse in the cycle after the last pair is accepted. In that cycle pair_valid_o and busy_o are 0 and remain_o is 0.
- R9: A start_i while idle with total_qw_i of 0 pulses done_o on the next cycle and offers no pair.
- R10: start_i is ignored while busy_o is high. The job in progress keeps its addresses and its count.
- R11: remain_o loads total_qw_i on an accepted start and drops by one on each accepted pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Job start pulse, taken only when idle |
| total_qw_i | input | 16 | Total quadwords in the job |
| run_qw_i | input | 10 | Quadwords per memory run, 0 means one run |
| skip_qw_i | input | 10 | Quadwords skipped in memory after each run |
| spad_base_i | input | 32 | Scratchpad start byte address |
| mem_base_i | input | 32 | Memory start byte address |
| busy_o | output | 1 | Job in progress |
| pair_valid_o | output | 1 | Address pair offered |
| pair_ready_i | input | 1 | Consumer accepts the pair |
| spad_addr_o | output | 32 | Scratchpad byte address of the pair |
| mem_addr_o | output | 32 | Memory byte address of the pair |
| remain_o | output | 16 | Quadwords not yet accepted |
| done_o | output | 1 | One-cycle pulse at job end |

## Verification
The assertions assume that pair_ready_i is a defined level on every clock. They also assume that start_i is a single-cycle pulse when issued while idle. They do not assume that job fields are held after start, because the block captures them when the job is accepted. The stimulus drives every input at the falling edge and pulses start for exactly one cycle per job. The exception is a deliberate second pulse during a busy job, which exercises the rule that start is ignored while busy. Ready follows both a constant-high pattern and a pseudo-random pattern, so that stalls fall both at run boundaries and in the middle of runs.

// File: rtl/sdag_pkg.sv
package sdag_pkg;
  localparam int unsigned QW_SHIFT = 4;
  localparam int unsigned QW_BYTES = 1 << QW_SHIFT;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sdag_state_e;
endpackage

// File: rtl/sdag_count_tracker.sv
module sdag_count_tracker #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (step && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign count = cnt_q;
  assign last  = (cnt_q == CNT_W'(1));

  // R11
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt_q != '0) |=> (count == $past(count) - CNT_W'(1)));
endmodule

// File: rtl/sdag_run_tracker.sv
module sdag_run_tracker #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] run_len,
  input  logic             step,
  output logic             run_end
);
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
      pos_q <= '0;
    end else if (load) begin
      len_q <= run_len;
      pos_q <= '0;
    end else if (step) begin
      if (run_end) pos_q <= '0;
      else         pos_q <= pos_q + CNT_W'(1);
    end
  end

  assign run_end = (pos_q == len_q - CNT_W'(1));

  // R4
  run_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && run_end) |=> (pos_q == '0));
endmodule

// File: rtl/sdag_addr_stepper.sv
module sdag_addr_stepper
  import sdag_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned RUN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] spad_base,
  input  logic [ADDR_W-1:0] mem_base,
  input  logic [RUN_W-1:0]  skip_qw,
  input  logic              step,
  input  logic              jump,
  output logic [ADDR_W-1:0] spad_addr,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam logic [ADDR_W-1:0] QW_INC = ADDR_W'(QW_BYTES);

  logic [RUN_W-1:0]  skip_q;
  logic [ADDR_W-1:0] spad_q;
  logic [ADDR_W-1:0] mem_q;
  logic [ADDR_W-1:0] gap_bytes;

  assign gap_bytes = ADDR_W'({1'b0, skip_q} + (RUN_W+1)'(1)) << QW_SHIFT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skip_q <= '0;
      spad_q <= '0;
      mem_q  <= '0;
    end else if (load) begin
      skip_q <= skip_qw;
      spad_q <= spad_base;
      mem_q  <= mem_base;
    end else if (step) begin
      spad_q <= spad_q + QW_INC;
      mem_q  <= mem_q + (jump ? gap_bytes : QW_INC);
    end
  end

  assign spad_addr = spad_q;
  assign mem_addr  = mem_q;

  // R3
  spad_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (spad_addr - $past(spad_addr) == QW_INC));

  // R4
  mem_inrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !jump) |=> (mem_addr - $past(mem_addr) == QW_INC));
endmodule

// File: rtl/strided_dma_addr_gen.sv
module strided_dma_addr_gen
  import sdag_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned RUN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  total_qw_i,
  input  logic [RUN_W-1:0]  run_qw_i,
  input  logic [RUN_W-1:0]  skip_qw_i,
  input  logic [ADDR_W-1:0] spad_base_i,
  input  logic [ADDR_W-1:0] mem_base_i,
  output logic              busy_o,
  output logic              pair_valid_o,
  input  logic              pair_ready_i,
  output logic [ADDR_W-1:0] spad_addr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [CNT_W-1:0]  remain_o,
  output logic              done_o
);
  sdag_state_e state_q;
  logic        done_q;
  logic        accept;
  logic        load_job;
  logic        xfer;
  logic        last_qw;
  logic        run_end;
  logic [CNT_W-1:0] eff_run;

  assign accept   = start_i && (state_q == ST_IDLE);
  assign load_job = accept && (total_qw_i != '0);
  assign xfer     = (state_q == ST_RUN) && pair_ready_i;
  assign eff_run  = (run_qw_i == '0) ? total_qw_i : CNT_W'(run_qw_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (total_qw_i == '0) done_q  <= 1'b1;
            else                  state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (xfer && last_qw) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sdag_count_tracker #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_job),
    .load_val (total_qw_i),
    .step     (xfer),
    .count    (remain_o),
    .last     (last_qw)
  );

  sdag_run_tracker #(.CNT_W(CNT_W)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_job),
    .run_len (eff_run),
    .step    (xfer),
    .run_end (run_end)
  );

  sdag_addr_stepper #(.ADDR_W(ADDR_W), .RUN_W(RUN_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_job),
    .spad_base (spad_base_i),
    .mem_base  (mem_base_i),
    .skip_qw   (skip_qw_i),
    .step      (xfer),
    .jump      (run_end),
    .spad_addr (spad_addr_o),
    .mem_addr  (mem_addr_o)
  );

  assign busy_o       = (state_q == ST_RUN);
  assign pair_valid_o = (state_q == ST_RUN);
  assign done_o       = done_q;

  // R7
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid_o && !pair_ready_i) |=>
      (pair_valid_o && $stable(spad_addr_o) && $stable(mem_addr_o)));

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!pair_valid_o && !busy_o && remain_o == '0));

  // R9
  zero_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && total_qw_i == '0) |=> (done_o && !pair_valid_o));

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && !pair_ready_i) |=> ($stable(remain_o) && $stable(spad_addr_o)));

  // R2
  first_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && total_qw_i != '0) |=>
      (pair_valid_o && spad_addr_o == $past(spad_base_i) && mem_addr_o == $past(mem_base_i)));
endmodule

// File: tb/test_strided_dma_addr_gen.sv
module test_strided_dma_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] total_qw_i = '0;
  logic [9:0]  run_qw_i = '0;
  logic [9:0]  skip_qw_i = '0;
  logic [31:0] spad_base_i = '0;
  logic [31:0] mem_base_i = '0;
  logic        pair_ready_i = 1'b0;
  logic        busy_o, pair_valid_o, done_o;
  logic [31:0] spad_addr_o, mem_addr_o;
  logic [15:0] remain_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int lfsr = 32'h1ACE5;
  string scen = "R1";

  // reference model state
  bit          m_busy = 0, m_done = 0;
  int unsigned m_remain = 0, m_pos = 0, m_rsz = 0, m_skip = 0;
  bit [31:0]   m_spad = 0, m_mem = 0;
  int          accepted = 0;

  always #2 clk = ~clk;

  strided_dma_addr_gen i_strided_dma_addr_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .total_qw_i(total_qw_i),
    .run_qw_i(run_qw_i), .skip_qw_i(skip_qw_i), .spad_base_i(spad_base_i),
    .mem_base_i(mem_base_i), .busy_o(busy_o), .pair_valid_o(pair_valid_o),
    .pair_ready_i(pair_ready_i), .spad_addr_o(spad_addr_o), .mem_addr_o(mem_addr_o),
    .remain_o(remain_o), .done_o(done_o)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) %s: actual %0h expected %0h at cycle %0d", req, scen, what, act, exp, cycles);
    end
  endtask

  task automatic compare();
    chk("R2", "valid", pair_valid_o, m_busy);
    chk("R2", "busy", busy_o, m_busy);
    chk("R8", "done", done_o, m_done);
    chk("R11", "remain", remain_o, m_remain);
    if (m_busy) begin
      chk("R3", "spad", spad_addr_o, m_spad);
      chk("R4", "mem", mem_addr_o, m_mem);
    end
  endtask

  // drive inputs, advance model over the next rising edge, then sample
  task automatic cycle(bit st, bit rdy);
    bit hs;
    start_i = st;
    pair_ready_i = rdy;
    hs = m_busy && rdy;
    if (!m_busy && st) begin
      m_done = (total_qw_i == 0);
      if (total_qw_i != 0) begin
        m_busy = 1; m_remain = total_qw_i; m_spad = spad_base_i; m_mem = mem_base_i;
        m_pos = 0; m_skip = skip_qw_i; m_rsz = (run_qw_i == 0) ? total_qw_i : run_qw_i;
        accepted = 0;
      end
    end else if (hs) begin
      accepted++;
      m_done = 0;
      m_spad += 16;
      if (m_remain == 1) begin
        m_busy = 0; m_done = 1;
      end else if (m_pos == m_rsz - 1) begin
        m_pos = 0; m_mem += 16 * (m_skip + 1);
      end else begin
        m_pos++; m_mem += 16;
      end
      m_remain--;
    end else begin
      m_done = 0;
    end
    @(negedge clk);
    cycles++;
    compare();
  endtask

  function automatic bit next_ready(bit randomised);
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
    return randomised ? ((lfsr & 3) != 0) : 1'b1;
  endfunction

  task automatic job(string tag, int total, int run, int skip, int sb, int mb,
                     bit rnd, bit restart_mid);
    int guard = 0;
    scen = tag;
    total_qw_i = 16'(total); run_qw_i = 10'(run); skip_qw_i = 10'(skip);
    spad_base_i = 32'(sb); mem_base_i = 32'(mb);
    cycle(1'b1, next_ready(rnd));
    total_qw_i = 16'h7; run_qw_i = 10'd1; skip_qw_i = 10'd9;
    spad_base_i = 32'hDEAD0000; mem_base_i = 32'hBEEF0000;
    while ((m_busy || m_done) && guard < 5000) begin
      guard++;
      cycle(restart_mid && guard == 3, next_ready(rnd));
    end
    cycle(1'b0, 1'b0);
    if (total != 0) chk("R6", "pairs accepted", accepted, total);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "valid", pair_valid_o, 0);
    chk("R1", "done", done_o, 0);
    chk("R1", "busy", busy_o, 0);
    chk("R1", "remain", remain_o, 0);
    rst_n = 1'b1;
    cycle(1'b0, 1'b1);
    job("R2 R4 runs of 4 skip 3", 10, 4, 3, 'h100, 'h8000, 0, 0);
    job("R6 partial last run", 7, 3, 1, 'h400, 'h2000, 1, 0);
    job("R5 zero run length", 6, 0, 5, 'h0, 'h10000, 0, 0);
    job("R7 back-pressure", 9, 2, 0, 'h40, 'h600, 1, 0);
    job("R9 zero total", 0, 3, 3, 'h40, 'h600, 0, 0);
    job("R10 start while busy", 8, 3, 2, 'h1000, 'h3000, 1, 1);
    job("R4 single-qw runs max skip", 4, 1, 1023, 'h20, 'h0, 0, 0);
    job("R3 long random", 40, 5, 7, 'h500, 'h9000, 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule